// File: doc/BRIEF.md
# Operand Address Fetch Generator

This block is the address-generation front end of a small 8-bit processor with a 16-bit address space. When the instruction decoder has identified one of four addressing modes, it hands the block the mode, the current index register value and the address of the first byte after the opcode. The block reads the operand-address bytes that the mode needs from a byte-wide program memory port, one byte per accepted transfer. It then forms the 16-bit effective address.

The result is presented with a one-cycle valid strobe. At the same time the block reports the total instruction length in bytes, so the program counter logic can step past the instruction. Two short forms reach only page zero. The 8-bit offset form adds two unsigned bytes and keeps the carry, so it can reach slightly beyond page zero. The extended form reaches the whole address space.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 2'b00 (page-zero direct) fetches exactly one byte, read from the request address. It produces the effective address {8'h00, byte} with an instruction length of 2.
- R2: Mode code 2'b01 (full extended) fetches two bytes, from the request address and the request address plus one. The first byte becomes bits 15:8 of the effective address and the second becomes bits 7:0. The instruction length is 3.
- R3: Mode code 2'b10 (indexed, no offset) fetches no bytes. It produces {8'h00, X} with an instruction length of 1, one cycle after acceptance.
- R4: Mode code 2'b11 (indexed, 8-bit offset) fetches one byte and produces the zero-extended 9-bit sum of that byte and X, so the highest reachable address is 16'h01FE. The instruction length is 2.
- R5: For each accepted request, ea_valid is high for exactly one cycle. req_ready is low from acceptance until that strobe has ended, and the next request can be accepted in the cycle after the strobe.
- R6: X is captured when the request is accepted. A later change of req_x does not affect the result.
- R7: A program byte is taken only in a cycle where both pm_req and pm_valid are high. While pm_valid is low, pm_addr holds its value. pm_addr advances by one, modulo 2^16, after each byte is taken. With no stalls, the strobe comes 1 + (bytes fetched) cycles after acceptance.
- R8: A synchronous active-high reset returns the block to idle: req_ready high, pm_req low and ea_valid low. Any fetch in progress is dropped without a strobe.
- R9: pm_req is never high while the block is idle, which is while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A mode request is offered |
| req_ready | output | 1 | Block is idle and takes the request this cycle |
| req_mode | input | 2 | Addressing mode code (00 direct, 01 extended, 10 indexed, 11 indexed+offset) |
| req_x | input | 8 | Index register value |
| req_pc | input | 16 | Address of the first byte after the opcode |
| pm_req | output | 1 | Program byte read request |
| pm_addr | output | 16 | Program byte address |
| pm_valid | input | 1 | Program byte is present this cycle |
| pm_data | input | 8 | Program byte |
| ea_valid | output | 1 | Effective address strobe, one cycle |
| ea_addr | output | 16 | Effective address |
| ins_len | output | 2 | Instruction length in bytes (1 to 3) |

## Verification
The bench drives the offset mode with both bytes at 8'hFF and expects 16'h01FE. A design that truncated the sum to 8 bits would return 16'h00FE, and one that sign-extended either byte would return a wrong upper byte. Extended requests start at 16'hFFFF, so the second fetch must come from 16'h0000. Byte order is checked so that a design swapping the latched bytes is caught. The memory model stalls every other cycle to expose a design that takes a byte without pm_valid or moves pm_addr during a stall. The index input is changed right after acceptance, so a design that reads X live produces a different address. A reset is applied mid-fetch, and a leftover strobe afterwards would mark a design that keeps stale state.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [1:0] {
        AM_DIR = 2'b00,
        AM_EXT = 2'b01,
        AM_IX0 = 2'b10,
        AM_IX1 = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FETCH = 2'b01,
        ST_DONE  = 2'b10
    } seq_st_e;

    // Number of operand-address bytes that follow the opcode
    function automatic logic [1:0] operand_bytes(amode_e m);
        case (m)
            AM_EXT:  return 2'd2;
            AM_IX0:  return 2'd0;
            default: return 2'd1;
        endcase
    endfunction

    // Total instruction length: opcode plus operand-address bytes
    function automatic logic [1:0] instr_len(amode_e m);
        return operand_bytes(m) + 2'd1;
    endfunction

endpackage

// File: rtl/opaddr_ea_calc.sv
module opaddr_ea_calc
    import opaddr_pkg::*;
#(
    parameter int unsigned DW = 8,
    localparam int unsigned AW = 2 * DW
) (
    input  logic [1:0]    mode,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] b_first,
    input  logic [DW-1:0] b_second,
    output logic [AW-1:0] ea,
    output logic [1:0]    len
);
    localparam int unsigned PADW = AW - DW - 1;

    logic [DW:0]   sum_w;
    logic [AW-1:0] ea_sum;

    // Offset mode: unsigned byte + unsigned index, carry kept in bit DW
    assign sum_w = {1'b0, b_first} + {1'b0, x};

    generate
        if (PADW > 0) begin : g_pad
            assign ea_sum = {{PADW{1'b0}}, sum_w};
        end else begin : g_nopad
            assign ea_sum = AW'(sum_w);
        end
    endgenerate

    always_comb begin
        unique case (amode_e'(mode))
            AM_DIR:  ea = {{DW{1'b0}}, b_first};
            AM_EXT:  ea = {b_first, b_second};
            AM_IX0:  ea = {{DW{1'b0}}, x};
            default: ea = ea_sum;
        endcase
        len = instr_len(amode_e'(mode));
    end

endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
    import opaddr_pkg::*;
#(
    parameter int unsigned DW = 8,
    localparam int unsigned AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_mode,
    input  logic [DW-1:0] req_x,
    input  logic [AW-1:0] req_pc,
    output logic          pm_req,
    output logic [AW-1:0] pm_addr,
    input  logic          pm_valid,
    input  logic [DW-1:0] pm_data,
    output logic          done,
    output logic [1:0]    held_mode,
    output logic [DW-1:0] held_x,
    output logic [DW-1:0] held_b_first,
    output logic [DW-1:0] held_b_second
);
    typedef struct packed {
        seq_st_e       st;
        amode_e        mode;
        logic [DW-1:0] x;
        logic [AW-1:0] pc;
        logic [DW-1:0] b_first;
        logic [DW-1:0] b_second;
        logic          second;
    } seq_s;

    seq_s s_d, s_q;
    amode_e req_m;

    assign req_m = amode_e'(req_mode);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.mode   = req_m;
                    s_d.x      = req_x;
                    s_d.pc     = req_pc;
                    s_d.second = 1'b0;
                    s_d.st     = (operand_bytes(req_m) == 2'd0) ? ST_DONE : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (pm_valid) begin
                    if (s_q.second) begin
                        s_d.b_second = pm_data;
                    end else begin
                        s_d.b_first = pm_data;
                    end
                    s_d.pc = s_q.pc + AW'(1);
                    if (!s_q.second && operand_bytes(s_q.mode) == 2'd2) begin
                        s_d.second = 1'b1;
                    end else begin
                        s_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready     = (s_q.st == ST_IDLE);
    assign pm_req        = (s_q.st == ST_FETCH);
    assign pm_addr       = s_q.pc;
    assign done          = (s_q.st == ST_DONE);
    assign held_mode     = s_q.mode;
    assign held_x        = s_q.x;
    assign held_b_first  = s_q.b_first;
    assign held_b_second = s_q.b_second;

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int unsigned DW = 8,
    localparam int unsigned AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_mode,
    input  logic [DW-1:0] req_x,
    input  logic [AW-1:0] req_pc,
    output logic          pm_req,
    output logic [AW-1:0] pm_addr,
    input  logic          pm_valid,
    input  logic [DW-1:0] pm_data,
    output logic          ea_valid,
    output logic [AW-1:0] ea_addr,
    output logic [1:0]    ins_len
);
    logic [1:0]    h_mode;
    logic [DW-1:0] h_x;
    logic [DW-1:0] h_b0;
    logic [DW-1:0] h_b1;

    opaddr_seq #(.DW(DW)) i_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_mode      (req_mode),
        .req_x         (req_x),
        .req_pc        (req_pc),
        .pm_req        (pm_req),
        .pm_addr       (pm_addr),
        .pm_valid      (pm_valid),
        .pm_data       (pm_data),
        .done          (ea_valid),
        .held_mode     (h_mode),
        .held_x        (h_x),
        .held_b_first  (h_b0),
        .held_b_second (h_b1)
    );

    opaddr_ea_calc #(.DW(DW)) i_calc (
        .mode     (h_mode),
        .x        (h_x),
        .b_first  (h_b0),
        .b_second (h_b1),
        .ea       (ea_addr),
        .len      (ins_len)
    );

endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
    parameter int unsigned DW = 8,
    localparam int unsigned AW = 2 * DW
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_mode,
    input logic [DW-1:0] req_x,
    input logic          pm_req,
    input logic [AW-1:0] pm_addr,
    input logic          pm_valid,
    input logic          ea_valid,
    input logic [AW-1:0] ea_addr,
    input logic [1:0]    ins_len
);
    localparam logic [AW-1:0] IX1_MAX = AW'(2 * ((2 ** DW) - 1));

    logic [1:0]    mode_q;
    logic [DW-1:0] x_q;
    logic          rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            mode_q <= 2'b00;
            x_q    <= '0;
        end else if (req_valid && req_ready) begin
            mode_q <= req_mode;
            x_q    <= req_x;
        end
    end

    p_dir_r1: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q == 2'b00) |-> (ins_len == 2'd2 && ea_addr[AW-1:DW] == '0));

    p_ext_len_r2: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q == 2'b01) |-> (ins_len == 2'd3));

    p_ix0_r3: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q == 2'b10) |-> (ins_len == 2'd1 && ea_addr[AW-1:DW] == '0));

    p_ix1_range_r4: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q == 2'b11) |-> (ins_len == 2'd2 && ea_addr <= IX1_MAX));

    p_one_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        ea_valid |=> !ea_valid);

    p_busy_r5: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> !req_ready);

    p_x_held_r6: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q == 2'b10) |-> (ea_addr[DW-1:0] == x_q));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (pm_req && !pm_valid) |=> (pm_req && $stable(pm_addr)));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (pm_req && pm_valid) |=> (!pm_req || pm_addr == AW'($past(pm_addr) + 1'b1)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !pm_req);

    // R8: the cycle after a reset edge shows the idle outputs
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_idle_r8: assert (req_ready && !pm_req && !ea_valid);
        end
    end

endmodule

bind opaddr_gen opaddr_gen_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mode  (req_mode),
    .req_x     (req_x),
    .pm_req    (pm_req),
    .pm_addr   (pm_addr),
    .pm_valid  (pm_valid),
    .ea_valid  (ea_valid),
    .ea_addr   (ea_addr),
    .ins_len   (ins_len)
);

// File: tb/test_opaddr_gen.sv
`timescale 1ns/1ps
module test_opaddr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_mode = 2'b00;
    logic [7:0]  req_x = 8'h00;
    logic [15:0] req_pc = 16'h0000;
    logic        pm_req;
    logic [15:0] pm_addr;
    logic        pm_valid;
    logic [7:0]  pm_data;
    logic        ea_valid;
    logic [15:0] ea_addr;
    logic [1:0]  ins_len;

    logic [7:0] mem [0:255];
    logic       stall_en = 1'b0;
    logic       stall = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    always @(posedge clk) stall <= stall_en ? ~stall : 1'b0;

    assign pm_valid = pm_req & ~stall;
    assign pm_data  = mem[pm_addr[7:0]];

    opaddr_gen i_opaddr_gen (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_mode (req_mode),
        .req_x (req_x), .req_pc (req_pc),
        .pm_req (pm_req), .pm_addr (pm_addr), .pm_valid (pm_valid), .pm_data (pm_data),
        .ea_valid (ea_valid), .ea_addr (ea_addr), .ins_len (ins_len)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_ea(input logic [1:0] m, input logic [7:0] x,
                                           input logic [15:0] pc);
        logic [15:0] pc1;
        pc1 = pc + 16'd1;
        case (m)
            2'b00:   return {8'h00, mem[pc[7:0]]};
            2'b01:   return {mem[pc[7:0]], mem[pc1[7:0]]};
            2'b10:   return {8'h00, x};
            default: return 16'(mem[pc[7:0]]) + 16'(x);
        endcase
    endfunction

    // One request: drive, watch fetches and strobe, compare
    task automatic run(input logic [1:0] m, input logic [7:0] x, input logic [15:0] pc,
                       input logic [7:0] x_late, input bit stl, input string req);
        logic [15:0] exp_ea;
        int          nb;
        int          nf;
        int          lat;
        bit          seen;
        bit          addr_ok;
        bit          busy_ok;
        exp_ea  = ref_ea(m, x, pc);
        nb      = (m == 2'b01) ? 2 : ((m == 2'b10) ? 0 : 1);
        nf      = 0;
        lat     = 1;
        seen    = 1'b0;
        addr_ok = 1'b1;
        busy_ok = 1'b1;
        @(negedge clk);
        stall_en = stl;
        chk(req_ready == 1'b1, "R5", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_mode = m; req_x = x; req_pc = pc;
        @(negedge clk);
        req_valid = 1'b0; req_x = x_late; req_pc = 16'hDEAD;
        for (int i = 0; i < 64 && !seen; i++) begin
            if (pm_req && pm_valid) begin
                if (pm_addr != 16'(pc + 16'(nf))) addr_ok = 1'b0;
                nf++;
            end
            if (ea_valid) begin
                seen = 1'b1;
            end else begin
                if (req_ready) busy_ok = 1'b0;
                @(negedge clk);
                lat++;
            end
        end
        chk(seen, req, "strobe seen", 32'(seen), 1);
        chk(ea_addr == exp_ea, req, "effective address", 32'(ea_addr), 32'(exp_ea));
        chk(ins_len == 2'(nb + 1), req, "length", 32'(ins_len), 32'(nb + 1));
        chk(nf == nb, "R7", "bytes fetched", 32'(nf), 32'(nb));
        chk(addr_ok, "R7", "fetch address sequence", 32'(addr_ok), 1);
        chk(busy_ok, "R5", "ready low while busy", 32'(busy_ok), 1);
        if (!stl) chk(lat == 1 + nb, "R7", "latency", 32'(lat), 32'(1 + nb));
        stall_en = 1'b0;
        @(negedge clk);
        chk(ea_valid == 1'b0, "R5", "single-cycle strobe", 32'(ea_valid), 0);
        chk(req_ready == 1'b1, "R5", "ready after strobe", 32'(req_ready), 1);
    endtask

    task automatic t_reset_state();
        chk(req_ready && !pm_req && !ea_valid, "R8", "idle outputs after reset",
            {29'd0, req_ready, pm_req, ea_valid}, 32'h4);
    endtask

    task automatic t_direct();
        mem[8'h10] = 8'hA7; mem[8'h11] = 8'hFF;
        run(2'b00, 8'h33, 16'h0010, 8'h33, 1'b0, "R1");
        run(2'b00, 8'h00, 16'h2311, 8'h00, 1'b0, "R1");
    endtask

    task automatic t_extended();
        mem[8'h34] = 8'hC1; mem[8'h35] = 8'h5E;
        run(2'b01, 8'h00, 16'h1234, 8'h00, 1'b0, "R2");
        mem[8'hFF] = 8'h9A; mem[8'h00] = 8'h0B;
        run(2'b01, 8'h00, 16'hFFFF, 8'h00, 1'b0, "R2");
    endtask

    task automatic t_idx0();
        run(2'b10, 8'h00, 16'h0400, 8'h00, 1'b0, "R3");
        run(2'b10, 8'hFF, 16'h0400, 8'hFF, 1'b0, "R3");
    endtask

    task automatic t_idx1();
        mem[8'h40] = 8'hFF;
        run(2'b11, 8'hFF, 16'h0040, 8'hFF, 1'b0, "R4");
        mem[8'h41] = 8'h80;
        run(2'b11, 8'h80, 16'h0041, 8'h80, 1'b0, "R4");
        mem[8'h42] = 8'h00;
        run(2'b11, 8'h00, 16'h0042, 8'h00, 1'b0, "R4");
    endtask

    task automatic t_x_capture();
        mem[8'h50] = 8'h20;
        run(2'b11, 8'h05, 16'h0050, 8'hEE, 1'b0, "R6");
        run(2'b10, 8'h3C, 16'h0000, 8'hC3, 1'b0, "R6");
    endtask

    task automatic t_stall();
        mem[8'h60] = 8'h7D; mem[8'h61] = 8'h42;
        run(2'b01, 8'h00, 16'h5560, 8'h00, 1'b1, "R7");
        run(2'b00, 8'h00, 16'h0061, 8'h00, 1'b1, "R7");
    endtask

    task automatic t_reset_mid();
        bit quiet;
        quiet = 1'b1;
        @(negedge clk);
        stall_en = 1'b1;
        req_valid = 1'b1; req_mode = 2'b01; req_pc = 16'h0060;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(req_ready && !pm_req && !ea_valid, "R8", "reset during fetch",
            {29'd0, req_ready, pm_req, ea_valid}, 32'h4);
        chk(!pm_req, "R9", "no fetch while idle", 32'(pm_req), 0);
        rst = 1'b0; stall_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ea_valid || pm_req) quiet = 1'b0;
        end
        chk(quiet, "R8", "no stale strobe after reset", 32'(quiet), 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_direct();
        t_extended();
        t_idx0();
        t_idx1();
        t_x_capture();
        t_stall();
        t_reset_mid();
        run(2'b11, 8'h01, 16'h00FE, 8'h01, 1'b0, "R4");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule